// File: doc/BRIEF.md
# Instruction TLB lookup and check

This block takes an instruction fetch address and decides where that fetch goes. It first sorts the 32-bit virtual address into a fixed region. The direct-mapped regions need no lookup and are answered at once. An internal-resource region is never translated. For the regions that are translated, it searches a four-entry, fully associative instruction TLB. Each entry holds a virtual page number, an address-space identifier, a valid bit, a shared-page bit, a user-access bit, a cacheable bit and a physical page number. Pages are 4 KB.

Each accepted fetch ends in exactly one outcome. The outcome is reported as a one-cycle result strobe that carries a 3-bit code and a physical address. The possible outcomes are a cached access, an uncached access, an internal access, a multiple-hit fault, an access-right fault, a TLB miss fault, or an address error. When the lookup misses, the block asks an external second-level TLB through a request/response port. If that TLB returns an entry, the block writes it over the least recently used entry and runs the lookup again. A flush input invalidates every entry in a single cycle.

The block takes one fetch at a time. While it waits on the second-level TLB it raises `busy` and ignores new requests.

Top module: `itlb_lookup`

## Requirements
- R1: In user mode (`priv_mode`=0), any fetch address with bit 31 set gives result code 6 (address error) with physical address 0. This applies in every region at or above 0x8000_0000, and no lookup takes place.
- R2: In privileged mode, an address in 0xE000_0000..0xFFFF_FFFF gives code 2 (internal). The physical address equals the fetch address.
- R3: In privileged mode, an address in 0xA000_0000..0xBFFF_FFFF gives code 1 (uncached). The physical address is the fetch address with bits 31:29 cleared.
- R4: In privileged mode, an address in 0x8000_0000..0x9FFF_FFFF gives code 0 (cached) when `icache_en`=1 and code 1 when it is 0. The physical address is the fetch address with bits 31:29 cleared.
- R5: An address in the translated regions (0x0000_0000..0x7FFF_FFFF, or 0xC000_0000..0xDFFF_FFFF in privileged mode) with `xlate_en`=0 is not translated. It gives code 0 or 1 according to `icache_en`, and its physical address has bits 31:29 cleared.
- R6: With `xlate_en`=1, an entry matches when it is valid and its page number equals address bits 31:12. Its identifier must also equal `cur_asid`, unless the entry is shared or `single_vm`=1 in privileged mode. A match makes no second-level request, and the physical address is the entry's page number followed by address bits 11:0.
- R7: When two or more entries match, the result is code 3 (multiple hit) with physical address 0.
- R8: On a single match in user mode, an entry whose user-access bit is 0 gives code 4 (access-right fault) with physical address 0. In privileged mode the same entry is allowed.
- R9: An allowed match gives code 0 only when both the entry's cacheable bit and `icache_en` are 1. Otherwise it gives code 1.
- R10: When no entry matches, `utlb_req` rises and holds the page number and identifier steady until `utlb_rsp_valid`. A returned hit is written into the TLB and the lookup is repeated, giving that entry's result. A returned miss, or a repeat that still misses, gives code 5 (miss) with physical address 0.
- R11: A refill overwrites the least recently used entry. An entry counts as used when it is refilled or gives a single match. Empty entries are filled in order 0,1,2,3 after reset.
- R12: `flush` clears every valid bit. A request that arrives in a flush cycle is dropped: no result follows, and the block stays idle.
- R13: For a fetch that needs no second-level request, `res_valid` is high for exactly the one cycle after the request cycle. During a miss, `busy` is high and no result is given until the second-level TLB answers.
- R14: After reset, no result is pending, the block is idle, and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Fetch request, taken when `busy` is low |
| req_vaddr | input | 32 | Fetch virtual address |
| priv_mode | input | 1 | 1 = privileged, 0 = user |
| cur_asid | input | 8 | Current address-space identifier |
| single_vm | input | 1 | Privileged fetches skip the identifier compare |
| xlate_en | input | 1 | Translation enable |
| icache_en | input | 1 | Instruction cache enable |
| busy | output | 1 | Miss handling in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_code | output | 3 | 0 cached, 1 uncached, 2 internal, 3 multi-hit, 4 access fault, 5 miss, 6 address error |
| res_paddr | output | 32 | Physical address (0 on faults) |
| utlb_req | output | 1 | Second-level lookup request |
| utlb_vpn | output | 20 | Page number looked up |
| utlb_asid | output | 8 | Identifier looked up |
| utlb_rsp_valid | input | 1 | Second-level answer strobe |
| utlb_rsp_hit | input | 1 | Second-level answer is a hit |
| utlb_rsp_vpn | input | 20 | Returned page number |
| utlb_rsp_asid | input | 8 | Returned identifier |
| utlb_rsp_shared | input | 1 | Returned shared bit |
| utlb_rsp_prot | input | 1 | Returned user-access bit |
| utlb_rsp_cache | input | 1 | Returned cacheable bit |
| utlb_rsp_ppn | input | 20 | Returned physical page number |

## Verification
The table-driven fetches cover every region. Each region is tried in both modes and with both enable bits flipped, which separates the region decode from the enable gating. Translated fetches then exercise the match rules. The same page is fetched with a matching identifier, a foreign identifier with and without `single_vm`, and through a shared entry. This separates the identifier bypasses from a plain page match. A shared and a private copy of one page are loaded together so that both match at once, and a user-protected page is fetched from both modes. A fill-then-touch sequence over five pages shows which entry a refill evicts, since only an evicted page makes a new second-level request. A flush that arrives together with a request shows both the dropped request and the cleared entries.

// File: rtl/itlb_lookup.sv
module itlb_lookup #(
  parameter int NUM_ENT = 4,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int OFF_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              req_valid,
  input  logic [31:0]       req_vaddr,
  input  logic              priv_mode,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              single_vm,
  input  logic              xlate_en,
  input  logic              icache_en,
  output logic              busy,
  output logic              res_valid,
  output logic [2:0]        res_code,
  output logic [31:0]       res_paddr,
  output logic              utlb_req,
  output logic [VPN_W-1:0]  utlb_vpn,
  output logic [ASID_W-1:0] utlb_asid,
  input  logic              utlb_rsp_valid,
  input  logic              utlb_rsp_hit,
  input  logic [VPN_W-1:0]  utlb_rsp_vpn,
  input  logic [ASID_W-1:0] utlb_rsp_asid,
  input  logic              utlb_rsp_shared,
  input  logic              utlb_rsp_prot,
  input  logic              utlb_rsp_cache,
  input  logic [VPN_W-1:0]  utlb_rsp_ppn
);
  localparam int VA_W  = VPN_W + OFF_W;
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam int CNT_W = $clog2(NUM_ENT + 1);
  localparam logic [2:0] C_CACHE = 3'd0, C_UNC = 3'd1, C_INT = 3'd2, C_MULTI = 3'd3,
                         C_PROT  = 3'd4, C_MISS = 3'd5, C_AERR = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RETRY} st_t;
  st_t st;

  logic [VPN_W-1:0]  e_vpn [NUM_ENT];
  logic [ASID_W-1:0] e_asid[NUM_ENT];
  logic [VPN_W-1:0]  e_ppn [NUM_ENT];
  logic [IDX_W-1:0]  e_age [NUM_ENT];
  logic [NUM_ENT-1:0] e_v, e_sh, e_pr, e_c;

  logic [VA_W-1:0]   q_va;
  logic [ASID_W-1:0] q_asid;
  logic              q_priv, q_svm, q_xl, q_ice;

  wire               idle   = (st == S_IDLE);
  wire [VA_W-1:0]    l_va   = idle ? req_vaddr : q_va;
  wire [ASID_W-1:0]  l_asid = idle ? cur_asid  : q_asid;
  wire               l_priv = idle ? priv_mode : q_priv;
  wire               l_svm  = idle ? single_vm : q_svm;
  wire               l_xl   = idle ? xlate_en  : q_xl;
  wire               l_ice  = idle ? icache_en : q_ice;
  wire [VPN_W-1:0]   l_vpn  = l_va[VA_W-1:OFF_W];
  wire [2:0]         l_top  = l_va[VA_W-1 -: 3];
  wire [VA_W-1:0]    l_mask = {3'b000, l_va[VA_W-4:0]};

  logic [NUM_ENT-1:0] hit;
  generate
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
      assign hit[g] = e_v[g] && (e_vpn[g] == l_vpn) &&
                      (e_sh[g] || (l_svm && l_priv) || (e_asid[g] == l_asid));
    end
  endgenerate

  logic [CNT_W-1:0] h_cnt;
  logic [IDX_W-1:0] h_idx, victim;
  always_comb begin
    h_cnt  = '0;
    h_idx  = '0;
    victim = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      h_cnt = h_cnt + CNT_W'(hit[i]);
      if (hit[i]) h_idx = IDX_W'(i);
      if (e_age[i] == IDX_W'(NUM_ENT - 1)) victim = IDX_W'(i);
    end
  end

  logic [2:0]      l_code;
  logic [VA_W-1:0] l_pa;
  logic            l_miss, l_touch;
  always_comb begin
    l_code  = C_UNC;
    l_pa    = '0;
    l_miss  = 1'b0;
    l_touch = 1'b0;
    if (!l_priv && l_va[VA_W-1]) begin
      l_code = C_AERR;
    end else if (l_top == 3'b111) begin
      l_code = C_INT;
      l_pa   = l_va;
    end else if (l_top == 3'b101) begin
      l_code = C_UNC;
      l_pa   = l_mask;
    end else if (l_top == 3'b100 || !l_xl) begin
      l_code = l_ice ? C_CACHE : C_UNC;
      l_pa   = l_mask;
    end else if (h_cnt > CNT_W'(1)) begin
      l_code = C_MULTI;
    end else if (h_cnt == '0) begin
      l_code = C_MISS;
      l_miss = 1'b1;
    end else begin
      l_touch = 1'b1;
      if (!l_priv && !e_pr[h_idx]) begin
        l_code = C_PROT;
      end else begin
        l_code = (e_c[h_idx] && l_ice) ? C_CACHE : C_UNC;
        l_pa   = {e_ppn[h_idx], l_va[OFF_W-1:0]};
      end
    end
  end

  wire refill = (st == S_WAIT) && utlb_rsp_valid && utlb_rsp_hit;
  wire upd_en = refill || (st == S_RETRY && l_touch) ||
                (idle && req_valid && !flush && l_touch);
  wire [IDX_W-1:0] upd_idx = (st == S_WAIT) ? victim : h_idx;
  wire [IDX_W-1:0] upd_age = e_age[upd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      e_v       <= '0;
      res_valid <= 1'b0;
      res_code  <= '0;
      res_paddr <= '0;
      q_va      <= '0;
      q_asid    <= '0;
      q_priv    <= 1'b0;
      q_svm     <= 1'b0;
      q_xl      <= 1'b0;
      q_ice     <= 1'b0;
      for (int i = 0; i < NUM_ENT; i++) e_age[i] <= IDX_W'(NUM_ENT - 1 - i);
    end else begin
      res_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid && !flush) begin
          q_va   <= req_vaddr;
          q_asid <= cur_asid;
          q_priv <= priv_mode;
          q_svm  <= single_vm;
          q_xl   <= xlate_en;
          q_ice  <= icache_en;
          if (l_miss) begin
            st <= S_WAIT;
          end else begin
            res_valid <= 1'b1;
            res_code  <= l_code;
            res_paddr <= l_pa;
          end
        end
        S_WAIT: if (utlb_rsp_valid) begin
          if (utlb_rsp_hit) begin
            e_v[victim] <= 1'b1;
            st          <= S_RETRY;
          end else begin
            res_valid <= 1'b1;
            res_code  <= C_MISS;
            res_paddr <= '0;
            st        <= S_IDLE;
          end
        end
        S_RETRY: begin
          res_valid <= 1'b1;
          res_code  <= l_code;
          res_paddr <= l_pa;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (upd_en) begin
        for (int i = 0; i < NUM_ENT; i++) begin
          if (IDX_W'(i) == upd_idx) e_age[i] <= '0;
          else if (e_age[i] < upd_age) e_age[i] <= e_age[i] + 1'b1;
        end
      end
      if (flush) e_v <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (refill) begin
      e_vpn[victim]  <= utlb_rsp_vpn;
      e_asid[victim] <= utlb_rsp_asid;
      e_ppn[victim]  <= utlb_rsp_ppn;
      e_sh[victim]   <= utlb_rsp_shared;
      e_pr[victim]   <= utlb_rsp_prot;
      e_c[victim]    <= utlb_rsp_cache;
    end
  end

  assign busy      = !idle;
  assign utlb_req  = (st == S_WAIT);
  assign utlb_vpn  = q_va[VA_W-1:OFF_W];
  assign utlb_asid = q_asid;
endmodule

// File: rtl/itlb_lookup_chk.sv
module itlb_lookup_chk #(
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              req_valid,
  input logic [31:0]       req_vaddr,
  input logic              priv_mode,
  input logic              busy,
  input logic              res_valid,
  input logic [2:0]        res_code,
  input logic [31:0]       res_paddr,
  input logic              utlb_req,
  input logic              utlb_rsp_valid,
  input logic [VPN_W-1:0]  utlb_vpn,
  input logic [ASID_W-1:0] utlb_asid
);
  a_r1_user_high_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !flush && !priv_mode && req_vaddr[31])
      |=> (res_valid && res_code == 3'd6));

  a_r2_internal_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !flush && priv_mode && req_vaddr[31:29] == 3'b111)
      |=> (res_valid && res_code == 3'd2 && res_paddr == $past(req_vaddr)));

  a_r7_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code >= 3'd3) |-> (res_paddr == 32'd0));

  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (utlb_req && !utlb_rsp_valid)
      |=> (utlb_req && $stable(utlb_vpn) && $stable(utlb_asid)));

  a_r12_flush_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && flush) |=> (!res_valid && !busy));

  a_r13_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    utlb_req |-> (busy && !res_valid));
endmodule

bind itlb_lookup itlb_lookup_chk #(.VPN_W(VPN_W), .ASID_W(ASID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
  .req_vaddr(req_vaddr), .priv_mode(priv_mode), .busy(busy),
  .res_valid(res_valid), .res_code(res_code), .res_paddr(res_paddr),
  .utlb_req(utlb_req), .utlb_rsp_valid(utlb_rsp_valid),
  .utlb_vpn(utlb_vpn), .utlb_asid(utlb_asid)
);

// File: tb/itlb_lookup_tb_top.sv
`timescale 1ns/1ps
module itlb_lookup_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 0, req_valid = 0, priv_mode = 0, single_vm = 0, xlate_en = 0, icache_en = 0;
  logic [31:0] req_vaddr = '0;
  logic [7:0]  cur_asid = '0;
  logic busy, res_valid, utlb_req;
  logic [2:0] res_code;
  logic [31:0] res_paddr;
  logic [19:0] utlb_vpn;
  logic [7:0]  utlb_asid;
  logic rsp_valid = 0, rsp_hit = 0, rsp_sh = 0, rsp_pr = 0, rsp_c = 0;
  logic [19:0] rsp_vpn = '0, rsp_ppn = '0;
  logic [7:0]  rsp_asid = '0;
  int total = 0, bad = 0, utlb_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  itlb_lookup dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .priv_mode(priv_mode), .cur_asid(cur_asid), .single_vm(single_vm), .xlate_en(xlate_en),
    .icache_en(icache_en), .busy(busy), .res_valid(res_valid), .res_code(res_code),
    .res_paddr(res_paddr), .utlb_req(utlb_req), .utlb_vpn(utlb_vpn), .utlb_asid(utlb_asid),
    .utlb_rsp_valid(rsp_valid), .utlb_rsp_hit(rsp_hit), .utlb_rsp_vpn(rsp_vpn),
    .utlb_rsp_asid(rsp_asid), .utlb_rsp_shared(rsp_sh), .utlb_rsp_prot(rsp_pr),
    .utlb_rsp_cache(rsp_c), .utlb_rsp_ppn(rsp_ppn)
  );

  // second-level TLB model: answers one cycle after the request rises
  always @(negedge clk) begin
    if (utlb_req && !rsp_valid) begin
      rsp_valid = 1; rsp_hit = 0; rsp_vpn = utlb_vpn; rsp_asid = utlb_asid;
      rsp_sh = 0; rsp_pr = 1; rsp_c = 1; rsp_ppn = '0;
      utlb_cnt++;
      case (utlb_vpn)
        20'h00010: if (utlb_asid == 8'h05) begin rsp_hit = 1; rsp_ppn = 20'h12345; end
        20'h00020: begin rsp_hit = 1; rsp_sh = 1; rsp_pr = 0; rsp_ppn = 20'h22222; end
        20'h00030: if (utlb_asid == 8'h05) begin rsp_hit = 1; rsp_c = 0; rsp_ppn = 20'h33333; end
        20'h00060: begin
          rsp_hit = 1;
          if (utlb_asid == 8'h05) rsp_ppn = 20'h66660;
          else begin rsp_sh = 1; rsp_ppn = 20'h66661; end
        end
        20'hC0001: if (utlb_asid == 8'h07) begin rsp_hit = 1; rsp_pr = 0; rsp_ppn = 20'h44444; end
        default: if (utlb_vpn >= 20'h00041 && utlb_vpn <= 20'h00045 && utlb_asid == 8'h05) begin
          rsp_hit = 1; rsp_ppn = 20'h50000 | utlb_vpn;
        end
      endcase
    end else begin
      rsp_valid = 0;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic fetch(input logic pr, input logic xl, input logic ice, input logic svm,
                       input logic [7:0] as, input logic [31:0] va,
                       output bit got, output logic [2:0] code, output logic [31:0] pa,
                       output int n);
    int n0;
    @(negedge clk);
    priv_mode = pr; xlate_en = xl; icache_en = ice; single_vm = svm;
    cur_asid = as; req_vaddr = va; req_valid = 1;
    n0 = utlb_cnt;
    @(negedge clk);
    req_valid = 0;
    got = 0; code = 'x; pa = 'x;
    for (int k = 0; k < 12 && !got; k++) begin
      if (res_valid) begin got = 1; code = res_code; pa = res_paddr; end
      else @(negedge clk);
    end
    n = utlb_cnt - n0;
  endtask

  typedef struct packed {
    logic pr, xl, ice, svm;
    logic [7:0] asid;
    logic [31:0] va;
    logic [2:0] code;
    logic [31:0] pa;
    logic [1:0] n;
    logic [7:0] rq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VT [NV] = '{
    '{1'b0,1'b1,1'b1,1'b0,8'h05,32'h8000_0100,3'd6,32'h0000_0000,2'd0,8'd1},  // R1
    '{1'b0,1'b1,1'b1,1'b0,8'h05,32'hE000_0000,3'd6,32'h0000_0000,2'd0,8'd1},  // R1
    '{1'b1,1'b1,1'b1,1'b0,8'h05,32'hE000_1234,3'd2,32'hE000_1234,2'd0,8'd2},  // R2
    '{1'b1,1'b1,1'b1,1'b0,8'h05,32'hA123_4567,3'd1,32'h0123_4567,2'd0,8'd3},  // R3
    '{1'b1,1'b1,1'b1,1'b0,8'h05,32'h8765_4321,3'd0,32'h0765_4321,2'd0,8'd4},  // R4
    '{1'b1,1'b1,1'b0,1'b0,8'h05,32'h8765_4321,3'd1,32'h0765_4321,2'd0,8'd4},  // R4
    '{1'b0,1'b0,1'b1,1'b0,8'h05,32'h1234_5678,3'd0,32'h1234_5678,2'd0,8'd5},  // R5
    '{1'b1,1'b0,1'b0,1'b0,8'h05,32'hC000_1ABC,3'd1,32'h0000_1ABC,2'd0,8'd5},  // R5
    '{1'b0,1'b1,1'b1,1'b0,8'h05,32'h0001_0ABC,3'd0,32'h1234_5ABC,2'd1,8'd10}, // R10 refill
    '{1'b0,1'b1,1'b1,1'b0,8'h05,32'h0001_0ABC,3'd0,32'h1234_5ABC,2'd0,8'd6},  // R6 hit
    '{1'b0,1'b1,1'b0,1'b0,8'h05,32'h0001_0FFF,3'd1,32'h1234_5FFF,2'd0,8'd9},  // R9
    '{1'b1,1'b1,1'b1,1'b1,8'h09,32'h0001_0004,3'd0,32'h1234_5004,2'd0,8'd6},  // R6 single_vm
    '{1'b0,1'b1,1'b1,1'b1,8'h09,32'h0001_0004,3'd5,32'h0000_0000,2'd1,8'd10}, // R10 miss
    '{1'b0,1'b1,1'b1,1'b0,8'h03,32'h0002_0010,3'd4,32'h0000_0000,2'd1,8'd8},  // R8 user
    '{1'b1,1'b1,1'b1,1'b0,8'h03,32'h0002_0010,3'd0,32'h2222_2010,2'd0,8'd8},  // R8 priv
    '{1'b0,1'b1,1'b1,1'b0,8'h05,32'h0003_0020,3'd1,32'h3333_3020,2'd1,8'd9},  // R9
    '{1'b0,1'b1,1'b1,1'b0,8'h05,32'h0006_0000,3'd0,32'h6666_0000,2'd1,8'd10}, // R10
    '{1'b0,1'b1,1'b1,1'b0,8'h06,32'h0006_0000,3'd0,32'h6666_1000,2'd1,8'd6},  // R6 shared
    '{1'b0,1'b1,1'b1,1'b0,8'h05,32'h0006_0000,3'd3,32'h0000_0000,2'd0,8'd7},  // R7
    '{1'b1,1'b1,1'b1,1'b0,8'h07,32'hC000_1008,3'd0,32'h4444_4008,2'd1,8'd6}   // R6 priv area
  };

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic lru_fetch(input logic [19:0] vpn, input int exp_n, input string rq);
    bit got; logic [2:0] c; logic [31:0] p; int n;
    fetch(1'b0, 1'b1, 1'b1, 1'b0, 8'h05, {vpn, 12'h010}, got, c, p, n);
    chk(got && c == 3'd0, rq, "lru code", {29'd0, c}, 32'd0);
    chk(p == {20'h50000 | vpn, 12'h010}, rq, "lru paddr", p, {20'h50000 | vpn, 12'h010});
    chk(n == exp_n, rq, "second-level requests", n, exp_n);
  endtask

  initial begin
    bit got; logic [2:0] c; logic [31:0] p; int n;
    repeat (3) @(negedge clk);
    // R14 reset state
    chk(!res_valid && !busy && !utlb_req, "R14", "reset outputs",
        {29'd0, res_valid, busy, utlb_req}, 32'd0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      fetch(VT[i].pr, VT[i].xl, VT[i].ice, VT[i].svm, VT[i].asid, VT[i].va, got, c, p, n);
      chk(got, $sformatf("R%0d", VT[i].rq), $sformatf("vec %0d result", i), {31'd0, got}, 32'd1);
      chk(c == VT[i].code, $sformatf("R%0d", VT[i].rq), $sformatf("vec %0d code", i),
          {29'd0, c}, {29'd0, VT[i].code});
      chk(p == VT[i].pa, $sformatf("R%0d", VT[i].rq), $sformatf("vec %0d paddr", i), p, VT[i].pa);
      chk(n == int'(VT[i].n), $sformatf("R%0d", VT[i].rq), $sformatf("vec %0d utlb count", i),
          n, {30'd0, VT[i].n});
    end

    // R13: strobe lasts one cycle, right after the request cycle
    @(negedge clk);
    priv_mode = 1; req_vaddr = 32'hA000_0040; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(res_valid, "R13", "strobe after request", {31'd0, res_valid}, 32'd1);
    @(negedge clk);
    chk(!res_valid, "R13", "strobe one cycle", {31'd0, res_valid}, 32'd0);

    // R13: busy during a miss, no early result
    priv_mode = 0; xlate_en = 1; cur_asid = 8'h05; req_vaddr = 32'h0007_0000; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(busy && !res_valid, "R13", "busy on miss", {30'd0, busy, res_valid}, 32'd2);
    repeat (6) @(negedge clk);

    // R14/R11: new reset, entries invalid, fill order and LRU eviction
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    lru_fetch(20'h00041, 1, "R14");
    lru_fetch(20'h00042, 1, "R11");
    lru_fetch(20'h00043, 1, "R11");
    lru_fetch(20'h00044, 1, "R11");
    lru_fetch(20'h00041, 0, "R11");
    lru_fetch(20'h00045, 1, "R11");
    lru_fetch(20'h00042, 1, "R11");
    lru_fetch(20'h00041, 0, "R11");
    lru_fetch(20'h00044, 0, "R11");
    lru_fetch(20'h00045, 0, "R11");
    lru_fetch(20'h00043, 1, "R11");

    // R12: flush with a request drops it and clears entries
    @(negedge clk);
    priv_mode = 0; xlate_en = 1; cur_asid = 8'h05; req_vaddr = 32'h0004_1010;
    req_valid = 1; flush = 1;
    @(negedge clk);
    req_valid = 0; flush = 0;
    for (int k = 0; k < 3; k++) begin
      chk(!res_valid && !busy, "R12", "flush drops request", {30'd0, res_valid, busy}, 32'd0);
      @(negedge clk);
    end
    lru_fetch(20'h00041, 1, "R12");

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end
endmodule